// File: doc/BRIEF.md
# Predicate Register Bank with Commit Gating

This block keeps a bank of one-bit guard flags and decides, for every instruction that arrives at the commit point, whether that instruction may take effect. Each instruction carries a selector field that picks one flag. When the picked flag is set, the block raises a commit enable so that the instruction's register-file write goes through. When the flag is clear, the block raises a squash so that the instruction retires as a no-op and makes no architectural write.

The flags are produced by compare operations. A single compare update names two target flags. The compare's condition is written to the first target and its inverse to the second target, so that one compare can guard both the then-path and the else-path of an if-converted region. Flag 0 always reads as set and ignores writes, so unguarded instructions select it. A flag written in a given cycle is already visible to an instruction that reads it in the same cycle.

The compare arithmetic, instruction decode and the main register file lie outside this block.

Top module: `pred_commit_gate`

## Requirements
- R1: While the active-low reset `rst_n` is low, and after it is released, every flag other than flag 0 reads as clear, so an instruction that selects any of flags 1 to 63 is squashed.
- R2: Flag 0 always reads as set. A compare that names index 0 as either target leaves flag 0 unchanged, and an instruction that selects index 0 always commits.
- R3: When `cmp_valid` is high at a rising clock edge, flag `cmp_tgt_true` takes the value `cmp_cond` and flag `cmp_tgt_false` takes the value `!cmp_cond`. An instruction reads flag number N when its 6-bit `ins_sel` equals N.
- R4: A read of a flag that a compare writes in the same cycle returns the value being written, not the stored value.
- R5: When both compare targets name the same nonzero flag, that flag takes `cmp_cond`, both when the write is forwarded and after the edge.
- R6: With `ins_valid` high, `commit_en` is high and `squash` is low when the selected flag is set, and the reverse when it is clear. With `ins_valid` low, both outputs are low.
- R7: A flag that no compare names in a cycle keeps its value across the edge.
- R8: With `cmp_valid` low, no flag changes, whatever the target and condition inputs hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously upstream |
| cmp_valid | input | 1 | A compare result is presented this cycle |
| cmp_tgt_true | input | 6 | Flag that receives the condition |
| cmp_tgt_false | input | 6 | Flag that receives the inverted condition |
| cmp_cond | input | 1 | Compare outcome |
| ins_valid | input | 1 | An instruction is at commit this cycle |
| ins_sel | input | 6 | Flag selector carried by the instruction |
| commit_en | output | 1 | The instruction's write may proceed |
| squash | output | 1 | The instruction is turned into a no-op |

## Verification
The bench goes after the same-cycle forward: a design without it would commit or squash on the stale flag value on the very cycle that a compare resolves the guard. It also drives compares whose two targets collide, where a design with the wrong priority would leave the inverted value behind, and compares that name flag 0, which a faulty design would let clear the always-true guard and so squash unguarded code. Full sweeps of all 64 selectors after reset, after a write to every index and after writes with `cmp_valid` low show any flag that reset, decode or a stray enable disturbs.

// File: rtl/pred_pkg.sv
package pred_pkg;
  localparam int unsigned NUM_FLAGS = 64;
  localparam int unsigned SEL_W     = $clog2(NUM_FLAGS);

  typedef logic [SEL_W-1:0]     sel_t;
  typedef logic [NUM_FLAGS-1:0] flag_vec_t;

  typedef struct packed {
    logic valid;
    sel_t tgt_true;
    sel_t tgt_false;
    logic cond;
  } cmp_upd_t;
endpackage

// File: rtl/pred_write_dec.sv
module pred_write_dec #(
  parameter int unsigned NUM_FLAGS = 64,
  localparam int unsigned SEL_W    = $clog2(NUM_FLAGS)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 upd_valid,
  input  logic [SEL_W-1:0]     upd_tgt_true,
  input  logic [SEL_W-1:0]     upd_tgt_false,
  input  logic                 upd_cond,
  output logic [NUM_FLAGS-1:0] wr_en,
  output logic [NUM_FLAGS-1:0] wr_data
);

  for (genvar i = 0; i < NUM_FLAGS; i++) begin : g_dec
    if (i == 0) begin : g_fixed
      assign wr_en[i]   = 1'b0;
      assign wr_data[i] = 1'b1;
    end else begin : g_wr
      logic hit_t;
      logic hit_f;
      always_comb begin
        hit_t      = upd_valid && (upd_tgt_true  == SEL_W'(i));
        hit_f      = upd_valid && (upd_tgt_false == SEL_W'(i));
        wr_en[i]   = hit_t | hit_f;
        wr_data[i] = hit_t ? upd_cond : ~upd_cond;
      end
    end
  end

  // R3: one compare touches at most two flags
  p_two_targets_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(wr_en) <= 2);

  // R8: no enables without a valid compare
  p_idle_no_write_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !upd_valid |-> (wr_en == '0));

  // R5: colliding targets carry the true-sense value
  p_collide_true_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_valid && upd_tgt_true == upd_tgt_false && upd_tgt_true != '0)
      |-> (wr_en[upd_tgt_true] && wr_data[upd_tgt_true] == upd_cond));

endmodule

// File: rtl/pred_bank.sv
module pred_bank #(
  parameter int unsigned NUM_FLAGS = 64
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_FLAGS-1:0] wr_en,
  input  logic [NUM_FLAGS-1:0] wr_data,
  output logic [NUM_FLAGS-1:0] flags_q
);

  for (genvar i = 0; i < NUM_FLAGS; i++) begin : g_bit
    if (i == 0) begin : g_const
      assign flags_q[i] = 1'b1;
    end else begin : g_reg
      logic d;
      logic q;
      always_comb begin
        d = q;
        if (wr_en[i]) d = wr_data[i];
      end
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        q <= 1'b0;
        else if (wr_en[i]) q <= d;
      end
      assign flags_q[i] = q;

      // R3: an enabled write lands on the next edge
      p_write_lands_r3: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en[i] |=> (flags_q[i] == $past(wr_data[i])));

      // R7: an untargeted flag holds
      p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en[i] |=> $stable(flags_q[i]));
    end
  end

endmodule

// File: rtl/pred_read_gate.sv
module pred_read_gate #(
  parameter int unsigned NUM_FLAGS = 64,
  localparam int unsigned SEL_W    = $clog2(NUM_FLAGS)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_FLAGS-1:0] flags_q,
  input  logic [NUM_FLAGS-1:0] wr_en,
  input  logic [NUM_FLAGS-1:0] wr_data,
  input  logic                 ins_valid,
  input  logic [SEL_W-1:0]     ins_sel,
  output logic                 commit_en,
  output logic                 squash
);

  logic [NUM_FLAGS-1:0] flags_fwd;
  logic                 guard;

  always_comb begin
    flags_fwd = (wr_en & wr_data) | (~wr_en & flags_q);
    guard     = flags_fwd[ins_sel];
    commit_en = ins_valid & guard;
    squash    = ins_valid & ~guard;
  end

  // R2: selector 0 never squashes
  p_zero_commits_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (ins_valid && ins_sel == '0) |-> commit_en);

  // R6: no decision without an instruction
  p_idle_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !ins_valid |-> (!commit_en && !squash));

  // R4: a same-cycle write decides the instruction
  p_forward_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (ins_valid && wr_en[ins_sel]) |-> (commit_en == wr_data[ins_sel]));

endmodule

// File: rtl/pred_commit_gate.sv
module pred_commit_gate
  import pred_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cmp_valid,
  input  logic [5:0] cmp_tgt_true,
  input  logic [5:0] cmp_tgt_false,
  input  logic       cmp_cond,
  input  logic       ins_valid,
  input  logic [5:0] ins_sel,
  output logic       commit_en,
  output logic       squash
);

  cmp_upd_t  upd;
  flag_vec_t wr_en;
  flag_vec_t wr_data;
  flag_vec_t flags_q;

  always_comb begin
    upd.valid     = cmp_valid;
    upd.tgt_true  = sel_t'(cmp_tgt_true);
    upd.tgt_false = sel_t'(cmp_tgt_false);
    upd.cond      = cmp_cond;
  end

  pred_write_dec #(.NUM_FLAGS(NUM_FLAGS)) u_dec (
    .clk           (clk),
    .rst_n         (rst_n),
    .upd_valid     (upd.valid),
    .upd_tgt_true  (upd.tgt_true),
    .upd_tgt_false (upd.tgt_false),
    .upd_cond      (upd.cond),
    .wr_en         (wr_en),
    .wr_data       (wr_data)
  );

  pred_bank #(.NUM_FLAGS(NUM_FLAGS)) u_bank (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_data (wr_data),
    .flags_q (flags_q)
  );

  pred_read_gate #(.NUM_FLAGS(NUM_FLAGS)) u_gate (
    .clk       (clk),
    .rst_n     (rst_n),
    .flags_q   (flags_q),
    .wr_en     (wr_en),
    .wr_data   (wr_data),
    .ins_valid (ins_valid),
    .ins_sel   (sel_t'(ins_sel)),
    .commit_en (commit_en),
    .squash    (squash)
  );

  // R1: bank is cleared while reset is held
  p_reset_clear_r1: assert property (@(posedge clk)
    !rst_n |-> (flags_q == flag_vec_t'(1)));

  // R6: the two decisions never coincide
  p_exclusive_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !(commit_en && squash));

endmodule

// File: tb/sim_pred_commit_gate.sv
module sim_pred_commit_gate;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       cmp_valid;
  logic [5:0] cmp_tgt_true;
  logic [5:0] cmp_tgt_false;
  logic       cmp_cond;
  logic       ins_valid;
  logic [5:0] ins_sel;
  logic       commit_en;
  logic       squash;

  int unsigned n_vec  = 0;
  int unsigned n_fail = 0;
  logic [63:0] model;
  logic [15:0] lfsr = 16'hACE1;

  always #10 clk = ~clk;

  pred_commit_gate u0 (
    .clk(clk), .rst_n(rst_n), .cmp_valid(cmp_valid),
    .cmp_tgt_true(cmp_tgt_true), .cmp_tgt_false(cmp_tgt_false),
    .cmp_cond(cmp_cond), .ins_valid(ins_valid), .ins_sel(ins_sel),
    .commit_en(commit_en), .squash(squash)
  );

  task automatic summary();
    $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
    $finish;
  endtask

  // One cycle: drive at falling edge, check mid-low-phase, commit at rising edge.
  task automatic step(input logic cv, input logic [5:0] t, input logic [5:0] f,
                      input logic c, input logic iv, input logic [5:0] s,
                      input string req);
    logic [63:0] nxt;
    logic        g, exp_c, exp_s;
    @(negedge clk);
    cmp_valid = cv; cmp_tgt_true = t; cmp_tgt_false = f; cmp_cond = c;
    ins_valid = iv; ins_sel = s;
    nxt = model;
    if (cv) begin
      if (f != 6'd0) nxt[f] = ~c;
      if (t != 6'd0) nxt[t] = c;
    end
    g = (s == 6'd0) ? 1'b1 : nxt[s];
    exp_c = iv & g;
    exp_s = iv & ~g;
    #5;
    n_vec++;
    if (commit_en !== exp_c || squash !== exp_s) begin
      n_fail++;
      $display("FAIL %s sel=%0d: commit_en/squash=%b%b expected %b%b",
               req, s, commit_en, squash, exp_c, exp_s);
    end
    @(posedge clk);
    model = nxt;
  endtask

  task automatic sweep(input string req);
    for (int s = 0; s < 64; s++) step(1'b0, 6'd0, 6'd0, 1'b0, 1'b1, 6'(s), req);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    model = 64'd0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  initial begin
    #(20 * 200000);
    n_fail++;
    $display("FAIL watchdog: run did not complete, got timeout expected finish");
    summary();
  end

  initial begin
    rst_n = 1'b0; cmp_valid = 0; cmp_tgt_true = 0; cmp_tgt_false = 0;
    cmp_cond = 0; ins_valid = 0; ins_sel = 0;
    model = 64'd0;
    do_reset();

    // R1 R2: cleared bank, flag 0 set
    sweep("R1");

    // R3 R4: write every index, read the true target in the same cycle
    for (int t = 1; t < 64; t++)
      step(1'b1, 6'(t), 6'((t * 5 + 11) % 64), (t % 3) != 0, 1'b1, 6'(t), "R4");
    // R4: read the false target in the same cycle
    for (int t = 1; t < 64; t++)
      step(1'b1, 6'(t), 6'((t * 7 + 3) % 64), (t % 2) != 0, 1'b1,
           6'((t * 7 + 3) % 64), "R4");
    sweep("R3");

    // R2: targeting flag 0 leaves it set
    step(1'b1, 6'd0, 6'd5, 1'b1, 1'b1, 6'd0, "R2");
    step(1'b1, 6'd6, 6'd0, 1'b0, 1'b1, 6'd0, "R2");
    step(1'b0, 6'd0, 6'd0, 1'b0, 1'b1, 6'd5, "R3");

    // R5: colliding targets, forwarded then stored
    step(1'b1, 6'd9, 6'd9, 1'b1, 1'b1, 6'd9, "R5");
    step(1'b0, 6'd0, 6'd0, 1'b0, 1'b1, 6'd9, "R5");
    step(1'b1, 6'd9, 6'd9, 1'b0, 1'b1, 6'd9, "R5");
    step(1'b0, 6'd0, 6'd0, 1'b0, 1'b1, 6'd9, "R5");

    // R8: targets present without cmp_valid
    for (int t = 1; t < 64; t++)
      step(1'b0, 6'(t), 6'(63 - t), t[0], 1'b1, 6'(t), "R8");
    sweep("R8");

    // R6: no instruction, no decision
    for (int s = 0; s < 64; s += 9) step(1'b1, 6'(s), 6'(s + 1), 1'b1, 1'b0, 6'(s), "R6");

    // R7 R3: pseudo-random traffic
    for (int k = 0; k < 600; k++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      step(lfsr[0] | lfsr[1], lfsr[7:2], lfsr[13:8], lfsr[14], lfsr[15] | lfsr[3],
           6'(lfsr[11:6] ^ lfsr[5:0]), "R7");
    end
    sweep("R7");

    // R1: reset mid-run clears everything again
    do_reset();
    sweep("R1");

    summary();
  end
endmodule